// File: doc/BRIEF.md
# Eight-Point Sum-of-Products Cosine Transform Row Engine

The engine accepts one row of eight signed samples and returns eight transform values, each formed as a weighted sum of all eight inputs. The weights are cosine values quantised to signed fixed point. A parameter chooses the forward or the inverse weight set. The arithmetic is time-multiplexed: one multiplier and one accumulator take 64 cycles per row. The multiplier leaves out the lowest partial-product columns to save area, and it can add a fixed or a data-dependent term to make up for the missing columns. After the last product of each output, that output is rounded, halved and saturated.

A row enters through a valid/ready handshake. `in_ready` is high only while the engine is idle, so any upstream source is held off for the whole 64-cycle computation. The result has no back-pressure: `out_valid` is high for a single cycle with all eight values on `out_coefs`, and the consumer must take them in that cycle. A 2-D transform uses this engine twice, once over rows and once over the transposed row results, with a transpose store outside the block.

Top module: `rowdct_engine`

## Requirements
- R1: During and after reset with no row accepted, `in_ready` is 1 and `out_valid` is 0.
- R2: A row is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 until the edge that raises `out_valid`. `in_valid` and `in_samples` have no effect on the result while `in_ready` is 0.
- R3: `out_valid` rises on the 64th rising edge after the accepting edge and is high for exactly one cycle.
- R4: Input k is `in_samples[k*SAMPLE_W +: SAMPLE_W]` and output k is `out_coefs[k*OUT_W +: OUT_W]`, both signed. The weight w(u,x) is round(2^COEF_FRAC · c(u) · cos((2x+1)uπ/16)), where c(0)=1/√2 and c(u)=1 otherwise. The forward form gives output u = Σx w(u,x)·in[x]. With INVERSE=1, output x = Σu w(u,x)·in[u].
- R5: Each product is the exact signed product minus the partial-product bits in columns below DROP_COLS. In variable correction mode (default, mode 2), the bits of column DROP_COLS−1 are added back at weight 2^DROP_COLS. In constant mode (1), round(((r−1)·2^r+1)/4) is added instead. In mode 0 nothing is added.
- R6: Each output is floor((S + 2^COEF_FRAC) / 2^(COEF_FRAC+1)) for the sum S of its eight products, clamped to the signed OUT_W range.
- R7: Every output is within 0.5·(Σ|in|/2^(COEF_FRAC+1) + 2) + 1 of the real-valued transform with a factor ½ (clamped to the output range).
- R8: A row of all-zero samples produces all-zero outputs in the default correction mode.
- R9: A new row may be accepted on the edge that ends the `out_valid` cycle. The values shown during that cycle belong to the previous row, and the new row's result is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row offered |
| in_ready | output | 1 | Engine idle, row can be taken |
| in_samples | input | 8*SAMPLE_W | Eight signed samples, index 0 in the low bits |
| out_valid | output | 1 | One-cycle pulse, results present |
| out_coefs | output | 8*OUT_W | Eight signed results, index 0 in the low bits |

## Verification
Two events can fall in the same cycle: the result pulse for one row and the acceptance of the next row. The bench makes this happen by holding `in_valid` high with a second row queued while the first row is still being computed. It then checks that `in_ready` and `out_valid` are high together at the sampling point before the accepting edge, that the pulsed values belong to the first row, and that the second row later matches its own bit-exact and real-valued expectations. Separately, a row is offered while the engine is busy, and the result of the row already accepted must not change.

// File: rtl/rowdct_pkg.sv
package rowdct_pkg;
  localparam int POINTS     = 8;
  localparam int IDX_W      = 3;
  localparam int CORR_NONE  = 0;
  localparam int CORR_CONST = 1;
  localparam int CORR_VAR   = 2;
  localparam int TAB_FRAC   = 14;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_e;

  // cos(k*pi/16) in Q14 for k = 0..8
  function automatic int cos_base_q14(input int k);
    case (k)
      0: return 16384;
      1: return 16069;
      2: return 15137;
      3: return 13623;
      4: return 11585;
      5: return 9102;
      6: return 6270;
      7: return 3196;
      default: return 0;
    endcase
  endfunction

  // cos(k*pi/16) in Q14 for any k >= 0, folded by symmetry
  function automatic int cos_any_q14(input int k);
    int m;
    m = k % 32;
    if (m > 16) m = 32 - m;
    if (m > 8) return -cos_base_q14(16 - m);
    return cos_base_q14(m);
  endfunction

  // weight for frequency u and position x, rescaled to frac bits with symmetric rounding
  function automatic int weight_q(input int u, input int x, input int frac);
    int t;
    int sh;
    t  = (u == 0) ? 11585 : cos_any_q14((2 * x + 1) * u);
    sh = TAB_FRAC - frac;
    if (t >= 0) return (t + (1 << (sh - 1))) >>> sh;
    return -((-t + (1 << (sh - 1))) >>> sh);
  endfunction
endpackage

// File: rtl/rowdct_coef_rom.sv
module rowdct_coef_rom
  import rowdct_pkg::*;
#(
  parameter int COEF_W    = 10,
  parameter int COEF_FRAC = 8,
  parameter int INVERSE   = 0
) (
  input  logic [IDX_W-1:0]         out_idx,
  input  logic [IDX_W-1:0]         in_idx,
  output logic signed [COEF_W-1:0] coef
);
  localparam int ENTRIES = POINTS * POINTS;

  logic signed [COEF_W-1:0] table_w [ENTRIES];

  for (genvar o = 0; o < POINTS; o++) begin : g_out
    for (genvar i = 0; i < POINTS; i++) begin : g_in
      // forward: out index is frequency; inverse: out index is position
      localparam int FREQ = (INVERSE != 0) ? i : o;
      localparam int POS  = (INVERSE != 0) ? o : i;
      localparam int VAL  = weight_q(FREQ, POS, COEF_FRAC);
      assign table_w[o * POINTS + i] = COEF_W'(VAL);
    end
  end

  assign coef = table_w[{out_idx, in_idx}];
endmodule

// File: rtl/rowdct_trunc_mult.sv
module rowdct_trunc_mult
  import rowdct_pkg::*;
#(
  parameter int A_W  = 10,
  parameter int B_W  = 10,
  parameter int DROP = 4,
  parameter int CORR = CORR_VAR
) (
  input  logic signed [A_W-1:0]     a,
  input  logic signed [B_W-1:0]     b,
  output logic signed [A_W+B_W-1:0] p
);
  localparam int P_W        = A_W + B_W;
  localparam int MAX_DROP   = (DROP > 0) ? (DROP - 1) * (2 ** DROP) + 1 : 0;
  localparam int CONST_CORR = (MAX_DROP + 2) / 4;
  localparam int CORR_HI    = (CORR == CORR_VAR) ? DROP * (2 ** DROP) :
                              (CORR == CORR_CONST) ? CONST_CORR : 0;
  localparam logic [P_W-1:0] SIGN_CONST =
    (P_W'(1) << (P_W - 1)) + (P_W'(1) << (B_W - 1)) + (P_W'(1) << (A_W - 1));

  if (DROP > A_W - 1 || DROP > B_W - 1) begin : g_bad_drop
    $error("DROP must leave the sign rows formed");
  end

  logic [P_W-1:0] col_sum;
  logic [P_W-1:0] fix_sum;

  always_comb begin
    logic pp;
    col_sum = SIGN_CONST;
    fix_sum = '0;
    for (int j = 0; j < B_W; j++) begin
      for (int i = 0; i < A_W; i++) begin
        pp = a[i] & b[j];
        if ((i == A_W - 1) != (j == B_W - 1)) pp = ~pp;
        if (i + j >= DROP) col_sum = col_sum + (P_W'(pp) << (i + j));
        else if (i + j == DROP - 1) fix_sum = fix_sum + (P_W'(pp) << DROP);
      end
    end
    if (CORR == CORR_CONST) col_sum = col_sum + P_W'(CONST_CORR);
    else if (CORR == CORR_VAR) col_sum = col_sum + fix_sum;
    p = col_sum;
  end

  logic signed [P_W-1:0] exact_p;
  logic signed [P_W-1:0] err_p;
  assign exact_p = P_W'(a) * P_W'(b);
  assign err_p   = p - exact_p;

  always_comb begin
    p_trunc_bound_r5: assert (err_p >= -MAX_DROP && err_p <= CORR_HI)
      else $error("truncated product outside error window");
    if (CORR != CORR_CONST && (a == '0 || b == '0)) begin
      p_zero_in_zero_out_r8: assert (p == '0)
        else $error("zero operand gave nonzero product");
    end
  end
endmodule

// File: rtl/rowdct_mac.sv
module rowdct_mac #(
  parameter int PROD_W = 20,
  parameter int OUT_W  = 10,
  parameter int FRAC   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  input  logic                     first,
  input  logic signed [PROD_W-1:0] prod,
  output logic signed [OUT_W-1:0]  rounded
);
  localparam int ACC_W = PROD_W + 3;
  localparam int SH_W  = ACC_W - FRAC - 1;
  localparam logic signed [SH_W-1:0] HI = SH_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SH_W-1:0] LO = SH_W'(-(1 << (OUT_W - 1)));

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] biased;
  logic signed [SH_W-1:0]  shifted;

  always_comb begin
    acc_d   = (first ? '0 : acc_q) + ACC_W'(prod);
    biased  = acc_d + (ACC_W'(1) <<< FRAC);
    shifted = SH_W'(biased >>> (FRAC + 1));
    if (shifted > HI)      rounded = {1'b0, {(OUT_W-1){1'b1}}};
    else if (shifted < LO) rounded = {1'b1, {(OUT_W-1){1'b0}}};
    else                   rounded = OUT_W'(shifted);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (step_en) acc_q <= acc_d;
  end

  p_acc_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && first) |=> (acc_q == ACC_W'($past(prod))))
    else $error("accumulator did not restart on first product");
endmodule

// File: rtl/rowdct_engine.sv
module rowdct_engine
  import rowdct_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int COEF_W    = 10,
  parameter int COEF_FRAC = 8,
  parameter int OUT_W     = 10,
  parameter int DROP_COLS = 4,
  parameter int CORR_MODE = CORR_VAR,
  parameter int INVERSE   = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [POINTS*SAMPLE_W-1:0] in_samples,
  output logic                      out_valid,
  output logic [POINTS*OUT_W-1:0]   out_coefs
);
  localparam int PROD_W    = SAMPLE_W + COEF_W;
  localparam int STEP_W    = 2 * IDX_W;
  localparam int STEPS     = POINTS * POINTS;
  localparam int LAT_W     = STEP_W + 1;

  state_e                        state_q;
  logic [STEP_W-1:0]             step_q;
  logic [POINTS*SAMPLE_W-1:0]    samp_q;
  logic [POINTS*OUT_W-1:0]       res_q;
  logic [IDX_W-1:0]              out_idx;
  logic [IDX_W-1:0]              in_idx;
  logic signed [SAMPLE_W-1:0]    cur_sample;
  logic signed [COEF_W-1:0]      cur_coef;
  logic signed [PROD_W-1:0]      prod;
  logic signed [OUT_W-1:0]       rounded;
  logic                          accept;
  logic                          running;

  assign in_ready   = (state_q == ST_IDLE);
  assign accept     = in_valid && in_ready;
  assign running    = (state_q == ST_RUN);
  assign out_idx    = step_q[STEP_W-1:IDX_W];
  assign in_idx     = step_q[IDX_W-1:0];
  assign cur_sample = samp_q[in_idx*SAMPLE_W +: SAMPLE_W];
  assign out_coefs  = res_q;

  rowdct_coef_rom #(
    .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .INVERSE(INVERSE)
  ) u_rom (
    .out_idx(out_idx), .in_idx(in_idx), .coef(cur_coef)
  );

  rowdct_trunc_mult #(
    .A_W(SAMPLE_W), .B_W(COEF_W), .DROP(DROP_COLS), .CORR(CORR_MODE)
  ) u_mult (
    .a(cur_sample), .b(cur_coef), .p(prod)
  );

  rowdct_mac #(
    .PROD_W(PROD_W), .OUT_W(OUT_W), .FRAC(COEF_FRAC)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .step_en(running),
    .first(in_idx == '0), .prod(prod), .rounded(rounded)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      samp_q    <= '0;
      res_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            samp_q  <= in_samples;
            step_q  <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          step_q <= step_q + 1'b1;
          if (in_idx == IDX_W'(POINTS - 1))
            res_q[out_idx*OUT_W +: OUT_W] <= rounded;
          if (step_q == STEP_W'(STEPS - 1)) begin
            state_q   <= ST_IDLE;
            out_valid <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // cycles since the last accepted row, for the latency check
  logic [LAT_W-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                  since_q <= '1;
    else if (accept)             since_q <= '0;
    else if (since_q != '1)      since_q <= since_q + 1'b1;
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_q == LAT_W'(STEPS)))
    else $error("result pulse at wrong distance from acceptance");

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid)
    else $error("result pulse longer than one cycle");

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready)
    else $error("still ready after acceptance");

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(samp_q))
    else $error("held row changed while busy");
endmodule

// File: tb/rowdct_engine_test.sv
module rowdct_engine_test;
  localparam int N    = 8;
  localparam int SW   = 10;
  localparam int OW   = 10;
  localparam int DROP = 4;
  localparam real PI  = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N*SW-1:0] in_samples = '0;
  logic in_ready, out_valid, in_ready_i, out_valid_i;
  logic [N*OW-1:0] out_f, out_i;

  always #5 clk = ~clk;

  rowdct_engine #(.INVERSE(0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .out_valid(out_valid), .out_coefs(out_f));

  rowdct_engine #(.INVERSE(1)) uut_inv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_i),
    .in_samples(in_samples), .out_valid(out_valid_i), .out_coefs(out_i));

  typedef struct {
    int    ef[N];
    int    ei[N];
    real   rf[N];
    real   ri[N];
    real   tol;
    int    acc_cyc;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic real cu(input int u);
    return (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
  endfunction

  function automatic int wq(input int u, input int x);
    return int'(256.0 * cu(u) * $cos((2 * x + 1) * u * PI / 16.0));
  endfunction

  // R5: exact product minus low columns, plus column DROP-1 moved up
  function automatic int tprod(input int a, input int b);
    int drop = 0;
    int fix = 0;
    for (int i = 0; i < DROP; i++)
      for (int j = 0; i + j < DROP; j++) begin
        drop += (((a >>> i) & 1) * ((b >>> j) & 1)) << (i + j);
        if (i + j == DROP - 1) fix += (((a >>> i) & 1) * ((b >>> j) & 1)) << DROP;
      end
    return a * b - drop + fix;
  endfunction

  // R6: round, halve, saturate
  function automatic int scale(input int s);
    int r;
    r = (s + 256) >>> 9;
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return r;
  endfunction

  function automatic real clampr(input real v);
    if (v > 511.0) return 511.0;
    if (v < -512.0) return -512.0;
    return v;
  endfunction

  function automatic item_t build(input int s[N], input string tag);
    item_t it;
    real mag = 0.0;
    for (int k = 0; k < N; k++) mag += (s[k] < 0) ? -s[k] : s[k];
    for (int o = 0; o < N; o++) begin
      int sf = 0;
      int si = 0;
      real af = 0.0;
      real ai = 0.0;
      for (int k = 0; k < N; k++) begin
        sf += tprod(s[k], wq(o, k));
        si += tprod(s[k], wq(k, o));
        af += cu(o) * $cos((2 * k + 1) * o * PI / 16.0) * s[k];
        ai += cu(k) * $cos((2 * o + 1) * k * PI / 16.0) * s[k];
      end
      it.ef[o] = scale(sf);
      it.ei[o] = scale(si);
      it.rf[o] = clampr(0.5 * af);
      it.ri[o] = clampr(0.5 * ai);
    end
    it.tol = 0.5 * (mag / 512.0 + 2.0) + 1.0;
    it.tag = tag;
    return it;
  endfunction

  task automatic send(input int s[N], input string tag, input bit expect_overlap);
    item_t it;
    for (int k = 0; k < N; k++) in_samples[k*SW +: SW] = SW'(s[k]);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    if (expect_overlap)
      chk(out_valid == 1'b1, "R9 pulse with acceptance", int'(out_valid), 1);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    it = build(s, tag);
    it.acc_cyc = cyc;
    q.push_back(it);
  endtask

  // scoreboard monitor
  bit prev_ov = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(!(out_valid && prev_ov), "R3 single pulse", int'(out_valid), 0);
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 unexpected pulse", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(cyc - it.acc_cyc == 64, "R3 latency", cyc - it.acc_cyc, 64);
          chk(out_valid_i == 1'b1, "R3 inverse pulse", int'(out_valid_i), 1);
          for (int o = 0; o < N; o++) begin
            int af;
            int ai;
            af = $signed(out_f[o*OW +: OW]);
            ai = $signed(out_i[o*OW +: OW]);
            chk(af == it.ef[o], {"R4 R5 R6 forward ", it.tag}, af, it.ef[o]);
            chk(ai == it.ei[o], {"R4 R5 R6 inverse ", it.tag}, ai, it.ei[o]);
            chk((af - it.rf[o] <= it.tol) && (it.rf[o] - af <= it.tol),
                {"R7 forward accuracy ", it.tag}, af, int'(it.rf[o]));
            chk((ai - it.ri[o] <= it.tol) && (it.ri[o] - ai <= it.tol),
                {"R7 inverse accuracy ", it.tag}, ai, int'(it.ri[o]));
          end
        end
      end
      prev_ov = out_valid;
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    int s[N];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 no pulse in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 no pulse after reset", int'(out_valid), 0);

    foreach (s[k]) s[k] = 0;
    send(s, "R8 zero row", 1'b0);
    foreach (s[k]) s[k] = 100;
    send(s, "R4 flat row", 1'b0);
    foreach (s[k]) s[k] = (k == 3) ? 400 : 0;
    send(s, "R4 impulse", 1'b0);
    foreach (s[k]) s[k] = (k % 2 == 0) ? 300 : -300;
    send(s, "R5 alternating", 1'b0);
    foreach (s[k]) s[k] = -256 + 73 * k;
    send(s, "R5 ramp", 1'b0);
    foreach (s[k]) s[k] = 511;
    send(s, "R6 high saturation", 1'b0);
    foreach (s[k]) s[k] = -512;
    send(s, "R6 low saturation", 1'b0);
    for (int r = 0; r < 5; r++) begin
      foreach (s[k]) s[k] = int'($urandom_range(0, 1023)) - 512;
      send(s, "R7 random", 1'b0);
    end

    // R2: offer a row while busy; it must not disturb the accepted one
    foreach (s[k]) s[k] = 37 * k - 120;
    send(s, "R2 busy", 1'b0);
    repeat (5) @(negedge clk);
    chk(in_ready == 1'b0, "R2 busy not ready", int'(in_ready), 0);
    for (int k = 0; k < N; k++) in_samples[k*SW +: SW] = SW'(-77 * k);
    in_valid = 1'b1;
    repeat (10) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R2 stays busy", int'(in_ready), 0);
    end
    in_valid = 1'b0;

    // R9: back-to-back rows, second accepted during the pulse of the first
    foreach (s[k]) s[k] = 200 - 50 * k;
    send(s, "R9 first", 1'b0);
    foreach (s[k]) s[k] = (k < 4) ? -150 : 250;
    send(s, "R9 second", 1'b1);

    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule